// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. It runs a small load/store subset: word load and store, register add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an absolute jump. Inside it are the program counter, a 32-entry register file, the ALU and a two-level control path. A main decoder turns the opcode into the datapath strobes and a 2-bit ALU class. An ALU decoder then combines that class with the function field to pick one of five ALU operations.

The core drives the instruction address and takes back the 32-bit instruction word in the same cycle. It drives the data address, the store data and a write strobe, and takes back the read data in the same cycle. Both memories sit outside the core and must answer combinationally. A data write lands at the same clock edge that retires the store.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low the instruction address is 0 and every register is cleared, without waiting for a clock edge.
- R2: For an ALU, load or store instruction, the next instruction address is the current one plus 4.
- R3: For opcode 000000, funct 100000 writes rs+rt, funct 100010 writes rs-rt, funct 100100 writes rs AND rt and funct 100101 writes rs OR rt, each into register rd.
- R4: For opcode 000000 with funct 101010, rd gets 1 when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R5: Opcode 100011 (load) drives the data address rs + sign-extended imm[15:0] and writes the returned word into rt.
- R6: Opcode 101011 (store) raises the write strobe, drives the address rs + sign-extended imm and drives rt as write data. It leaves the register file unchanged.
- R7: Opcode 000100 (branch) moves to PC+4+(sign-extended imm shifted left by 2) when rs equals rt, and to PC+4 otherwise. It writes neither registers nor memory.
- R8: Opcode 000010 (jump) moves to {bits 31:28 of PC+4, instr[25:0], 00}.
- R9: Register 0 always reads as zero, and writes to it are dropped.
- R10: The data write strobe is low for every instruction other than a store.
- R11: The ALU class is add for load/store, subtract for branch and function-field-driven for opcode 000000. The ALU select codes are and=000, or=001, add=010, sub=110 and slt=111, and select bit 2 inverts operand B and forces the carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Instruction address (program counter) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o |
| dmem_we_o | output | 1 | Data write strobe |

## Verification
A wrong next-PC choice, whether a branch taken in error or a bad jump target, shows on imem_addr_o in the very next cycle. A bad register value stays hidden until some later instruction exposes it. It appears on dmem_addr_o when the register is used as a load/store base, or on dmem_wdata_o when the register is stored. For that reason every program ends by storing all 32 registers, so any corruption is exposed before the run stops. A strobe that fires in error shows as dmem_we_o high in the same cycle, and it also leaves a changed memory word that the final memory comparison catches.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OPC_ALU   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    ACLS_ADD   = 2'b00,
    ACLS_SUB   = 2'b01,
    ACLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef enum logic [2:0] {
    ASEL_AND = 3'b000,
    ASEL_OR  = 3'b001,
    ASEL_ADD = 3'b010,
    ASEL_SUB = 3'b110,
    ASEL_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic     dst_rd;
    logic     b_imm;
    logic     wb_mem;
    logic     rf_we;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{dst_rd: 1'b0, b_imm: 1'b0, wb_mem: 1'b0, rf_we: 1'b0,
               mem_we: 1'b0, branch: 1'b0, jump: 1'b0, cls: ACLS_ADD};
    case (op_i)
      OPC_ALU: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.cls    = ACLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.rf_we  = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.cls    = ACLS_SUB;
      end
      OPC_JUMP: ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_cls_e   cls_i,
  input  logic [5:0] funct_i,
  output alu_sel_e   sel_o
);
  always_comb begin
    case (cls_i)
      ACLS_ADD: sel_o = ASEL_ADD;
      ACLS_SUB: sel_o = ASEL_SUB;
      default: begin
        case (funct_i)
          FN_ADD:  sel_o = ASEL_ADD;
          FN_SUB:  sel_o = ASEL_SUB;
          FN_AND:  sel_o = ASEL_AND;
          FN_OR:   sel_o = ASEL_OR;
          FN_SLT:  sel_o = ASEL_SLT;
          default: sel_o = ASEL_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_sel_e     sel_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  logic         negate;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         lt;

  assign negate = sel_i[2];
  assign b_eff  = negate ? ~b_i : b_i;
  assign sum    = a_i + b_eff + {{(W-1){1'b0}}, negate};
  // signed compare: differing signs decide directly, else the difference sign
  assign lt     = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : sum[W-1];

  always_comb begin
    case (sel_i[1:0])
      2'b00:   res_o = a_i & b_i;
      2'b01:   res_o = a_i | b_i;
      2'b10:   res_o = sum;
      default: res_o = {{(W-1){1'b0}}, lt};
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = regs_q[ra_a_i];
  assign rd_b_o = regs_q[ra_b_i];

  assert_r0_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_a_i == '0) |-> (rd_a_o == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            dmem_we_o
);
  logic [XLEN-1:0]   pc_q, pc_d, pc_inc, br_tgt, jmp_tgt;
  logic [5:0]        opc, funct;
  logic [REG_AW-1:0] rs, rt, rd, wa;
  logic [15:0]       imm;
  logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_res, wb_data;
  logic              alu_zero;
  ctrl_t             ctrl;
  alu_sel_e          alu_sel;

  assign opc   = imem_data_i[31:26];
  assign rs    = imem_data_i[25:21];
  assign rt    = imem_data_i[20:16];
  assign rd    = imem_data_i[15:11];
  assign funct = imem_data_i[5:0];
  assign imm   = imem_data_i[15:0];

  assign imm_ext = {{(XLEN-16){imm[15]}}, imm};

  sc_main_dec u_main_dec (
    .op_i   (opc),
    .ctrl_o (ctrl)
  );

  sc_alu_dec u_alu_dec (
    .cls_i   (ctrl.cls),
    .funct_i (funct),
    .sel_o   (alu_sel)
  );

  sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (rs),
    .ra_b_i (rt),
    .rd_a_o (rs_val),
    .rd_b_o (rt_val),
    .we_i   (ctrl.rf_we),
    .wa_i   (wa),
    .wd_i   (wb_data)
  );

  assign alu_b = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .sel_i  (alu_sel),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  assign wa      = ctrl.dst_rd ? rd : rt;
  assign wb_data = ctrl.wb_mem ? dmem_rdata_i : alu_res;

  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + (imm_ext << 2);
  assign jmp_tgt = {pc_inc[XLEN-1:28], imem_data_i[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                    pc_d = jmp_tgt;
    else if (ctrl.branch && alu_zero) pc_d = br_tgt;
    else                              pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_res;
  assign dmem_wdata_o = rt_val;
  assign dmem_we_o    = ctrl.mem_we;

  assert_store_no_rf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !ctrl.rf_we);

  assert_beq_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == OPC_BEQ) |-> (!ctrl.rf_we && !dmem_we_o));

  assert_seq_pc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.branch && !ctrl.jump) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  assert_mem_uses_add_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mem_we || ctrl.wb_mem) |-> (alu_sel == ASEL_ADD));

  assert_jump_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |=> (pc_q[27:0] == $past({imem_data_i[25:0], 2'b00})));
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam logic [5:0] O_ALU = 6'b000000, O_LW = 6'b100011, O_SW = 6'b101011,
                         O_BEQ = 6'b000100, O_J = 6'b000010;
  localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_AND = 6'b100100,
                         F_OR = 6'b100101, F_SLT = 6'b101010;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] m_mem [256];
  logic [31:0] m_reg [32];
  string       reg_tag [32];
  logic [31:0] m_pc;
  string       prev_tag;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) if (rst_ni && dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  sc_core uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .dmem_we_o    (dmem_we)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    return {O_ALU, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {O_J, 26'(word)};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic wr_reg(input logic [4:0] d, input logic [31:0] v, input string t);
    if (d != 5'd0) begin
      m_reg[d] = v;
      reg_tag[d] = t;
    end
  endtask

  // store all registers to words 128..159, then halt on a self-jump
  task automatic add_dump(input int start);
    for (int i = 0; i < 32; i++) imem[start+i] = enc_i(O_SW, 0, i, 512 + 4*i);
    imem[start+32] = enc_j(start+32);
  endtask

  task automatic step(output bit done);
    logic [31:0] ins, a, b, res, addr, nxt;
    logic [4:0]  s, t, d;
    logic        exp_we;
    string       tg;
    ins = imem[m_pc[9:2]];
    chk(imem_addr == m_pc, prev_tag, imem_addr, m_pc);
    s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
    a = m_reg[s]; b = m_reg[t];
    nxt = m_pc + 32'd4; tg = "R2"; exp_we = 1'b0;
    case (ins[31:26])
      O_ALU: begin
        case (ins[5:0])
          F_ADD:   begin res = a + b; wr_reg(d, res, "R3/R11"); end
          F_SUB:   begin res = a - b; wr_reg(d, res, "R3/R11"); end
          F_AND:   begin res = a & b; wr_reg(d, res, "R3/R11"); end
          F_OR:    begin res = a | b; wr_reg(d, res, "R3/R11"); end
          F_SLT:   begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; wr_reg(d, res, "R4"); end
          default: ;
        endcase
      end
      O_LW: begin
        addr = a + sext(ins[15:0]);
        chk(dmem_addr == addr, "R5", dmem_addr, addr);
        wr_reg(t, m_mem[addr[9:2]], "R5");
      end
      O_SW: begin
        exp_we = 1'b1;
        addr = a + sext(ins[15:0]);
        chk(dmem_addr == addr, "R6", dmem_addr, addr);
        chk(dmem_wdata == b, {"R6/", reg_tag[t]}, dmem_wdata, b);
        m_mem[addr[9:2]] = b;
      end
      O_BEQ: begin
        tg = "R7";
        if (a == b) nxt = m_pc + 32'd4 + (sext(ins[15:0]) << 2);
      end
      O_J: begin
        tg = "R8";
        nxt = {nxt[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
    chk(dmem_we == exp_we, exp_we ? "R6" : "R10", {31'd0, dmem_we}, {31'd0, exp_we});
    done = (ins[31:26] == O_J) && (nxt == m_pc);
    m_pc = nxt;
    prev_tag = tg;
  endtask

  task automatic run_prog();
    bit done;
    @(negedge clk);
    rst_ni = 1'b0;
    #3;
    chk(imem_addr == 32'd0, "R1", imem_addr, 32'd0);
    for (int i = 0; i < 32; i++) begin m_reg[i] = '0; reg_tag[i] = "R1"; end
    reg_tag[0] = "R9";
    m_pc = '0;
    prev_tag = "R1";
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    done = 1'b0;
    for (int cyc = 0; cyc < 2000 && !done; cyc++) begin
      step(done);
      @(negedge clk);
      #1;
    end
    if (!done) chk(1'b0, "R2 watchdog", m_pc, 32'd0);
    for (int i = 0; i < 256; i++) chk(dmem[i] == m_mem[i], "R6", dmem[i], m_mem[i]);
  endtask

  task automatic load_data();
    for (int i = 0; i < 256; i++) begin
      dmem[i] = $urandom;
      m_mem[i] = dmem[i];
      imem[i] = 32'd0;
    end
  endtask

  task automatic gen_random();
    localparam int BODY = 150;
    int r, tgt;
    load_data();
    for (int i = 0; i < BODY; i++) begin
      r = $urandom % 100;
      if (i < 8) imem[i] = enc_i(O_LW, 0, i + 1, ($urandom % 64) * 4);
      else if (r < 15) imem[i] = enc_i(O_LW, 0, 1 + $urandom % 31, ($urandom % 64) * 4);
      else if (r < 25) imem[i] = enc_i(O_SW, 0, $urandom % 32, ($urandom % 64) * 4);
      else if (r < 35) imem[i] = enc_r($urandom % 32, $urandom % 32, $urandom % 32, F_ADD);
      else if (r < 45) imem[i] = enc_r($urandom % 32, $urandom % 32, $urandom % 32, F_SUB);
      else if (r < 55) imem[i] = enc_r($urandom % 32, $urandom % 32, $urandom % 32, F_AND);
      else if (r < 65) imem[i] = enc_r($urandom % 32, $urandom % 32, $urandom % 32, F_OR);
      else if (r < 75) imem[i] = enc_r($urandom % 32, $urandom % 32, $urandom % 32, F_SLT);
      else if (r < 88) begin
        int s, t, off;
        s = $urandom % 32;
        t = ($urandom % 2 == 0) ? s : $urandom % 32;
        off = $urandom % 4;
        if (i + 1 + off > BODY) off = 0;
        imem[i] = enc_i(O_BEQ, s, t, off);
      end else begin
        tgt = i + 1 + $urandom % 4;
        if (tgt > BODY) tgt = BODY;
        imem[i] = enc_j(tgt);
      end
    end
    add_dump(BODY);
  endtask

  task automatic gen_directed();
    load_data();
    dmem[0] = 32'h8000_0005; m_mem[0] = dmem[0];
    dmem[1] = 32'h0000_0003; m_mem[1] = dmem[1];
    dmem[2] = 32'd16;        m_mem[2] = dmem[2];
    imem[0]  = enc_i(O_LW, 0, 1, 0);
    imem[1]  = enc_i(O_LW, 0, 2, 4);
    imem[2]  = enc_r(1, 2, 3, F_SLT);
    imem[3]  = enc_r(2, 1, 4, F_SLT);
    imem[4]  = enc_r(1, 2, 0, F_ADD);
    imem[5]  = enc_r(2, 1, 5, F_SUB);
    imem[6]  = enc_i(O_LW, 0, 6, 8);
    imem[7]  = enc_i(O_SW, 6, 5, -4);
    imem[8]  = enc_i(O_LW, 6, 7, -12);
    imem[9]  = enc_i(O_BEQ, 1, 2, 1);
    imem[10] = enc_r(1, 2, 8, F_AND);
    imem[11] = enc_i(O_BEQ, 2, 7, 1);
    imem[12] = enc_r(1, 2, 9, F_OR);
    imem[13] = enc_r(1, 2, 10, F_OR);
    imem[14] = enc_j(16);
    imem[15] = enc_r(1, 1, 11, F_ADD);
    add_dump(16);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < 6; p++) begin
      gen_random();
      run_prog();
    end
    gen_directed();
    run_prog();
    chk(dmem[128+3] == 32'd1, "R4 neg<pos", dmem[128+3], 32'd1);
    chk(dmem[128+4] == 32'd0, "R4 pos<neg", dmem[128+4], 32'd0);
    chk(dmem[128] == 32'd0, "R9 r0 write dropped", dmem[128], 32'd0);
    chk(dmem[3] == 32'h7FFF_FFFE, "R3 sub via negative offset store", dmem[3], 32'h7FFF_FFFE);
    chk(dmem[128+7] == 32'd3, "R5 negative offset load", dmem[128+7], 32'd3);
    chk(dmem[128+8] == 32'd1, "R3 and after untaken branch", dmem[128+8], 32'd1);
    chk(dmem[128+9] == 32'd0, "R7 taken branch skips", dmem[128+9], 32'd0);
    chk(dmem[128+10] == 32'h8000_0007, "R3 or", dmem[128+10], 32'h8000_0007);
    chk(dmem[128+11] == 32'd0, "R8 jump skips", dmem[128+11], 32'd0);
    chk(dmem[128+20] == 32'd0, "R1 register cleared by reset", dmem[128+20], 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual %h expected %h", imem_addr, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule